// File: doc/BRIEF.md
# Dynamic Priority Preemptive Output Arbiter

This block decides which of four input ports may drive one shared output channel. Each cycle it receives a request bit and a small unsigned priority number for every port; the priority numbers come from a separate calculator. A port wins only while it requests, and the winner holds the channel for a whole wormhole packet, from its head flit to its tail flit. A waiting port whose priority is strictly higher than the holder's takes the channel at once. The grant output is one-hot and registered.

For fairness, the arbiter keeps a private decay offset for each port. Every cycle a port holds the channel, its offset grows by one. The port's effective priority is its input priority minus its offset, floored at zero. A long packet therefore loses ground to ports that are waiting, and can be preempted by them. The offset is cleared when a new packet header is presented at that port. Ports with equal effective priority are served in rotating order, starting after the most recently granted port.

Top module: `dyn_prio_arb`

## Requirements
- R1: `grant` has at most one bit set. A bit can become set only for a port whose `req` bit was high in the cycle before.
- R2: When the channel is free, the requesting port with the largest effective priority is granted at the next clock edge. Example: ports 0, 1 and 3 request with priorities 0, 3 and 2, and port 2 has priority 1. Then `grant` = 4'b0010.
- R3: A port whose `req` bit is low is never chosen, however large its priority.
- R4: A holder is replaced at the next edge when another requesting port has a strictly larger effective priority. An equal priority does not preempt.
- R5: Without preemption, the holder keeps the grant while it requests. When `tail` of the holding port is high, `grant` is all zero for the following cycle, and arbitration restarts in the cycle after that.
- R6: A port's effective priority is its `prio` field minus its decay offset, and is never below zero. The offset rises by one at each edge where the port holds the grant and its effective priority is non-zero. A `head` pulse at that port clears the offset, and takes precedence over the increment.
- R7: Ties in effective priority are broken in index order, starting at the port after the last newly granted one (wrapping from 3 to 0). After reset the search starts at port 0.
- R8: When no port requests, `grant` is all zero after the next edge. If the holder drops its request, a fresh arbitration runs in that same cycle.
- R9: A low `rst_n` at a clock edge clears all grants, all decay offsets and the tie pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | NPORT (4) | Per-port request for the output channel |
| prio | input | NPORT*PW (12) | Per-port priority; port i occupies bits [i*PW +: PW]; larger value means more urgent |
| head | input | NPORT (4) | Per-port pulse marking a newly latched packet header; clears that port's decay offset |
| tail | input | NPORT (4) | Per-port tail-flit marker; releases the channel when seen from the holder |
| grant | output | NPORT (4) | Registered one-hot grant |

## Verification
The assertions rely on three things about the inputs: priorities are sampled only at the rising edge, `tail` matters only for the port currently holding the grant, and `head` may arrive at any port in any cycle, including the holder. The stimulus respects these by driving all inputs at the falling edge. Its directed phases cover the worked example, a high-priority port that does not request, preemption, decay followed by preemption, and rotation among equal priorities. A long pseudo-random phase then drives random requests, priorities and `head`/`tail` pulses in every combination, including tail and head on the holder in the same cycle, and compares each grant with an arithmetic model built from the requirements.

// File: rtl/darb_pkg.sv
package darb_pkg;

   // next index in a ring of n ports
   function automatic int unsigned ring_next(input int unsigned i, input int unsigned n);
      return (i + 1) % n;
   endfunction

endpackage

// File: rtl/darb_decay.sv
module darb_decay #(
   parameter int PW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] prio,
   input  logic          head,
   input  logic          held,
   output logic [PW-1:0] eff
);

   logic [PW-1:0] off_q;

   assign eff = (prio > off_q) ? PW'(prio - off_q) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         off_q <= '0;
      else if (head)
         off_q <= '0;
      else if (held && (eff != '0))
         off_q <= off_q + 1'b1;
   end

   // R6
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!held && !head) |=> $stable(off_q));

   // R6
   off_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      head |=> (off_q == '0));

endmodule

// File: rtl/darb_pick.sv
module darb_pick #(
   parameter int NPORT = 4,
   parameter int PW    = 3,
   parameter int IW    = 2
) (
   input  logic [NPORT-1:0]    cand,
   input  logic [NPORT*PW-1:0] eff_flat,
   input  logic [IW-1:0]       ptr,
   output logic [NPORT-1:0]    win
);

   always_comb begin
      logic          found;
      logic [PW-1:0] best;
      int            sel;
      found = 1'b0;
      best  = '0;
      sel   = 0;
      win   = '0;
      for (int k = 0; k < NPORT; k++) begin
         int idx;
         logic [PW-1:0] e;
         idx = (int'(ptr) + k) % NPORT;
         e   = eff_flat[idx*PW +: PW];
         if (cand[idx] && (!found || (e > best))) begin
            found = 1'b1;
            best  = e;
            sel   = idx;
         end
      end
      if (found)
         win[sel] = 1'b1;
   end

   // R3
   pick_req_chk: assert final ((win & ~cand) == '0);

endmodule

// File: rtl/dyn_prio_arb.sv
module dyn_prio_arb #(
   parameter int NPORT = 4,
   parameter int PW    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NPORT-1:0]    req,
   input  logic [NPORT*PW-1:0] prio,
   input  logic [NPORT-1:0]    head,
   input  logic [NPORT-1:0]    tail,
   output logic [NPORT-1:0]    grant
);
   import darb_pkg::*;

   localparam int IW = (NPORT > 1) ? $clog2(NPORT) : 1;

   generate
      if (NPORT < 2) begin : g_bad_nport
         $error("dyn_prio_arb: NPORT must be at least 2");
      end
      if (PW < 1) begin : g_bad_pw
         $error("dyn_prio_arb: PW must be at least 1");
      end
   endgenerate

   logic [NPORT-1:0]    grant_q, grant_d, win;
   logic [NPORT*PW-1:0] eff_flat;
   logic [IW-1:0]       ptr_q, ptr_d;
   logic [PW-1:0]       hold_eff;
   logic                live, tail_hit, preempt;

   genvar g;
   generate
      for (g = 0; g < NPORT; g++) begin : g_port
         darb_decay #(.PW(PW)) i_decay (
            .clk  (clk),
            .rst_n(rst_n),
            .prio (prio[g*PW +: PW]),
            .head (head[g]),
            .held (grant_q[g]),
            .eff  (eff_flat[g*PW +: PW])
         );
      end
   endgenerate

   darb_pick #(.NPORT(NPORT), .PW(PW), .IW(IW)) i_pick (
      .cand    (req),
      .eff_flat(eff_flat),
      .ptr     (ptr_q),
      .win     (win)
   );

   assign live     = |(grant_q & req);
   assign tail_hit = |(grant_q & tail);

   always_comb begin
      hold_eff = '0;
      preempt  = 1'b0;
      for (int i = 0; i < NPORT; i++)
         if (grant_q[i]) hold_eff = eff_flat[i*PW +: PW];
      for (int i = 0; i < NPORT; i++)
         if (req[i] && !grant_q[i] && (eff_flat[i*PW +: PW] > hold_eff))
            preempt = 1'b1;
   end

   always_comb begin
      if (tail_hit)
         grant_d = '0;
      else if (live && !preempt)
         grant_d = grant_q;
      else
         grant_d = win;
   end

   always_comb begin
      ptr_d = ptr_q;
      if ((grant_d != '0) && (grant_d != grant_q))
         for (int i = 0; i < NPORT; i++)
            if (grant_d[i]) ptr_d = IW'(ring_next(i, NPORT));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= '0;
         ptr_q   <= '0;
      end else begin
         grant_q <= grant_d;
         ptr_q   <= ptr_d;
      end
   end

   assign grant = grant_q;

   // R1
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_q));

   // R1
   grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_q != '0) |-> ((grant_q & ~$past(req)) == '0));

   // R5
   tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant_q & tail)) |=> (grant_q == '0));

   // R8
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |=> (grant_q == '0));

   // R4
   preempt_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !tail_hit && preempt) |=> (grant_q != $past(grant_q)));

endmodule

// File: tb/test_dyn_prio_arb.sv
`timescale 1ns/100ps
module test_dyn_prio_arb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  req = '0, head = '0, tail = '0;
   logic [11:0] prio = '0;
   logic [3:0]  grant;

   int vectors = 0, fails = 0;
   bit done = 0;

   int         m_off[4];
   logic [3:0] m_g;
   int         m_ptr;

   always #2.5 clk = ~clk;

   dyn_prio_arb i_dyn_prio_arb (
      .clk(clk), .rst_n(rst_n), .req(req), .prio(prio),
      .head(head), .tail(tail), .grant(grant)
   );

   function automatic int effm(int i, logic [11:0] p);
      int pv;
      pv = int'(p[i*3 +: 3]);
      return (pv > m_off[i]) ? pv - m_off[i] : 0;
   endfunction

   task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: grant=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst_n = 1'b0; req = '0; head = '0; tail = '0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 4; i++) m_off[i] = 0;
      m_g = '0; m_ptr = 0;
      check(grant, 4'b0000, tag);
      rst_n = 1'b1;
   endtask

   task automatic step(input logic [3:0] r, input logic [11:0] p,
                       input logic [3:0] h, input logic [3:0] t, input string tag);
      int         e[4];
      int         holder, best, sel;
      bit         pre, found;
      logic [3:0] exp;
      @(negedge clk);
      req = r; prio = p; head = h; tail = t;
      for (int i = 0; i < 4; i++) e[i] = effm(i, p);
      holder = -1;
      for (int i = 0; i < 4; i++) if (m_g[i]) holder = i;
      exp = '0;
      if (holder >= 0 && t[holder]) begin
         exp = '0;
      end else begin
         pre = 0;
         if (holder >= 0 && r[holder])
            for (int j = 0; j < 4; j++)
               if (j != holder && r[j] && e[j] > e[holder]) pre = 1;
         if (holder >= 0 && r[holder] && !pre) begin
            exp = m_g;
         end else begin
            found = 0; best = 0; sel = 0;
            for (int k = 0; k < 4; k++) begin
               int idx;
               idx = (m_ptr + k) % 4;
               if (r[idx] && (!found || e[idx] > best)) begin
                  found = 1; best = e[idx]; sel = idx;
               end
            end
            if (found) exp[sel] = 1'b1;
         end
      end
      for (int i = 0; i < 4; i++) begin
         if (h[i]) m_off[i] = 0;
         else if (m_g[i] && e[i] > 0) m_off[i] = m_off[i] + 1;
      end
      if (exp != '0 && exp != m_g)
         for (int i = 0; i < 4; i++) if (exp[i]) m_ptr = (i + 1) % 4;
      m_g = exp;
      @(posedge clk);
      #1;
      check(grant, exp, tag);
   endtask

   function automatic logic [11:0] pk(int p3, int p2, int p1, int p0);
      return {3'(p3), 3'(p2), 3'(p1), 3'(p0)};
   endfunction

   initial begin
      for (int i = 0; i < 4; i++) m_off[i] = 0;
      m_g = '0; m_ptr = 0;
      do_reset("R9 reset");

      // R2 worked example: R0,R1,R3 request, priorities p3=2 p2=1 p1=3 p0=0
      step(4'b1011, pk(2,1,3,0), 4'b0000, 4'b0000, "R2 example");
      check(grant, 4'b0010, "R2 grant1 only");
      // R5 hold with equal-priority competitor, then tail releases
      step(4'b1011, pk(3,1,3,0), 4'b0000, 4'b0000, "R5 hold");
      step(4'b1011, pk(3,1,3,0), 4'b0000, 4'b0010, "R5 tail");
      check(grant, 4'b0000, "R5 idle after tail");
      // R3 non-requesting port with top priority ignored
      step(4'b0111, pk(7,1,2,4), 4'b1111, 4'b0000, "R3 ignore");
      check(grant, 4'b0001, "R3 port0 wins");
      // R4 preemption by strictly higher requester
      step(4'b0101, pk(0,6,2,4), 4'b0000, 4'b0000, "R4 preempt");
      check(grant, 4'b0100, "R4 port2 takes");
      // R8 no requests
      step(4'b0000, pk(7,7,7,7), 4'b0000, 4'b0000, "R8 idle");
      check(grant, 4'b0000, "R8 all low");

      // R6 decay then preemption: port0 prio5 holds, port1 prio3 waits
      do_reset("R9 reset again");
      step(4'b0001, pk(0,0,3,5), 4'b0001, 4'b0000, "R6 start");
      for (int n = 0; n < 6; n++)
         step(4'b0011, pk(0,0,3,5), 4'b0000, 4'b0000, "R6 decay");
      check(grant, 4'b0010, "R6 port1 after decay");
      // R6 head clears offset: port0 new header, port1 now holds and decays
      step(4'b0011, pk(0,0,3,5), 4'b0001, 4'b0000, "R6 head clear");

      // R7 ties rotate
      do_reset("R9 reset tie");
      for (int n = 0; n < 6; n++) begin
         step(4'b1111, pk(4,4,4,4), 4'b1111, 4'b0000, "R7 tie grant");
         step(4'b1111, pk(4,4,4,4), 4'b1111, 4'b1111, "R7 tie tail");
      end

      // R1 pseudo-random sweep
      for (int n = 0; n < 4000; n++) begin
         logic [3:0]  r, h, t;
         logic [11:0] p;
         r = 4'($urandom);
         p = 12'($urandom);
         h = 4'($urandom) & 4'($urandom);
         t = ($urandom % 4 == 0) ? 4'($urandom) : 4'b0000;
         step(r, p, h, t, "R1 sweep");
         if ($countones(grant) > 1) check(grant, 4'b0000, "R1 onehot");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule